// File: doc/BRIEF.md
# Buffered I2C Master Transfer Sequencer

This block is the byte-level engine of an I2C controller. Software programs it through a small word-addressed register file. That file holds a control word, a target address, up to three register-address bytes, transmit and receive byte counts, and interrupt enable and pending words. It also holds two 32-byte data buffers, each seen as eight 32-bit words with byte lanes packed least-significant first. The engine never touches SCL or SDA itself. It hands one command at a time (START, STOP, write a byte, read a byte) to a separate phase generator and waits for that generator's completion pulse.

A transfer opens with a START request. A write to a count register then launches one chunk of work in the current mode. In transmit mode it sends buffered bytes, the first of which is the address byte. In receive mode it clocks in bytes. In register mode the engine first sends the write address and the selected register-address bytes, then a repeated START and the read address, and then receives. Reads of more than 32 bytes are done as further receive-mode chunks with no START. A STOP request closes the transfer, and clearing the enable bit abandons it at once.

Register word map (reg_addr): 0 control, 1 address, 2 register-address, 3 transmit count, 4 receive count, 5 interrupt enable, 6 interrupt pending, 8..15 transmit buffer, 16..23 receive buffer.

Top module: `i2cs_top`

## Requirements
- R1: After reset, cmd_valid and irq are low and the control and pending words read back as zero.
- R2: Control bit 0 enables the engine and bits [2:1] select the mode (0 transmit, 1 register-then-receive, 2 receive). Setting bit 3 while idle issues a START command and sets pending bit 4. The engine clears bit 3 and bit 4 of the control word itself when it acts on them.
- R3: After START, writing the transmit count (values above 32 act as 32) sends that many bytes from the transmit buffer in order. Buffer byte k is lane k mod 4 (bits [8j+7:8j]) of word k div 4. Each byte sets pending bit 0, and the last one also sets pending bit 2.
- R4: Writing the receive count (up to 32 per chunk) reads that many bytes. Byte k lands in lane k mod 4 of receive word k div 4. Each byte sets pending bit 1, and the last one also sets pending bit 3.
- R5: With control bit 5 set, the final byte of a receive chunk is answered with NACK and all others with ACK. With bit 5 clear, every byte gets ACK.
- R6: In register mode, the first receive chunk after START is preceded by a fixed sequence. First the address byte (register bits [7:1] with bit 0 = 0) if bit 24 of the address register is set. Then register-address lane x (bits [8x+7:8x]) for each x in 0..2 whose bit 24+x is set, in lane order. Then a repeated START and the address byte with bit 0 = 1.
- R7: A receive chunk started in mode 2 without a START issues only read commands, with no START and no address byte.
- R8: A NACK on a written byte sets pending bit 6. With control bit 6 set, the engine then issues STOP without setting pending bit 2. With bit 6 clear, it sends the remaining bytes.
- R9: Setting control bit 4 while the engine waits between chunks issues a STOP command, sets pending bit 5 and returns the engine to idle.
- R10: A pending bit is set only while its enable bit is set. Writing 1 to a pending bit clears it. irq is the OR of the enabled pending bits.
- R11: Writing the control word with bit 0 clear withdraws any outstanding command within two cycles and returns the engine to idle. A later START then begins a fresh transfer.
- R12: Command codes are 0 START, 1 STOP, 2 write byte, 3 read byte. cmd_op and cmd_byte hold steady while cmd_valid is high until the cycle of phy_done. phy_nack and phy_rdata are taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |
| cmd_valid | output | 1 | Command outstanding to the phase generator |
| cmd_op | output | 2 | Command code |
| cmd_byte | output | 8 | Byte to send for write commands |
| cmd_nack | output | 1 | Answer a read byte with NACK |
| phy_done | input | 1 | One-cycle completion of the current command |
| phy_nack | input | 1 | Target answered NACK to a written byte |
| phy_rdata | input | 8 | Byte received by a read command |

## Verification
On every cycle, the assertions check the following. The command held towards the phase generator does not change while it is pending. The byte index stays inside the latched chunk count. Received bytes are never stored in transmit mode. No pending bit rises while its enable is clear. A START request taken by the engine clears itself. What the bench scenarios alone can show is the order and content of whole command sequences, which includes the register-mode header with its lane skipping and read-address bit, the ACK/NACK pattern of a chunk, and the NACK-driven early STOP. They also show the little-endian packing of received bytes and the abort by clearing the enable bit.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [1:0] {OP_START = 2'd0, OP_STOP = 2'd1, OP_WR = 2'd2, OP_RD = 2'd3} op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_HOLD, S_HDR, S_RST, S_RADR, S_TX, S_RX, S_STOP
  } seq_e;

  localparam logic [1:0] MODE_TX  = 2'd0;
  localparam logic [1:0] MODE_REG = 2'd1;

  localparam int EV_N      = 7;
  localparam int EV_BSENT  = 0;
  localparam int EV_BRCV   = 1;
  localparam int EV_TXDONE = 2;
  localparam int EV_RXDONE = 3;
  localparam int EV_START  = 4;
  localparam int EV_STOP   = 5;
  localparam int EV_NACK   = 6;
endpackage

// File: rtl/i2cs_irq.sv
module i2cs_irq #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ien_we,
  input  logic         ipd_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] evt,
  output logic [N-1:0] ien,
  output logic [N-1:0] ipd,
  output logic         irq
);
  logic [N-1:0] ien_d, ipd_d;

  always_comb begin
    ien_d = ien_we ? wdata : ien;
    ipd_d = (ipd & ~(ipd_we ? wdata : '0)) | (evt & ien);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= '0;
      ipd <= '0;
    end else begin
      ien <= ien_d;
      ipd <= ipd_d;
    end
  end

  assign irq = |(ipd & ien);

  // R10: no pending bit appears while its enable was clear
  p_ipd_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ipd & ~$past(ipd) & ~$past(ien)) == '0))
    else $error("pending bit set while disabled");
endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
  import i2cs_pkg::*;
#(
  parameter int IDXW = 5,
  localparam int CNTW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [1:0]      mode,
  input  logic            start_req,
  input  logic            stop_req,
  input  logic            lastack,
  input  logic            actack,
  input  logic            tx_go,
  input  logic            rx_go,
  input  logic [CNTW-1:0] tx_cnt,
  input  logic [CNTW-1:0] rx_cnt,
  input  logic [3:0]      hdr_vld,
  input  logic [31:0]     hdr_byte,
  input  logic [7:0]      rd_addr,
  input  logic [7:0]      tx_byte,
  output logic [IDXW-1:0] idx,
  output logic            rx_we,
  output logic            start_tk,
  output logic            stop_tk,
  output logic [EV_N-1:0] evt,
  output logic            cmd_valid,
  output logic [1:0]      cmd_op,
  output logic [7:0]      cmd_byte,
  output logic            cmd_nack,
  input  logic            phy_done,
  input  logic            phy_nack
);
  seq_e            st_q, st_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [1:0]      lane_q, lane_d;
  logic            hdr_q, hdr_d;
  logic            last;
  logic [2:0]      nl;

  // lowest valid header lane at or above 'from'; bit 2 = found
  function automatic logic [2:0] next_lane(input logic [3:0] v, input logic [2:0] from);
    logic [2:0] r;
    r = '0;
    for (int k = 3; k >= 0; k--)
      if (v[k] && (3'(k) >= from)) r = {1'b1, 2'(k)};
    return r;
  endfunction

  assign last = (({1'b0, idx_q} + 1'b1) == cnt_q);

  always_comb begin
    st_d = st_q; idx_d = idx_q; cnt_d = cnt_q; lane_d = lane_q; hdr_d = hdr_q;
    evt = '0; rx_we = 1'b0; start_tk = 1'b0; stop_tk = 1'b0; nl = '0;
    case (st_q)
      S_IDLE: if (start_req) begin st_d = S_START; start_tk = 1'b1; end
      S_START: if (phy_done) begin
        evt[EV_START] = 1'b1; hdr_d = (mode == MODE_REG); st_d = S_HOLD;
      end
      S_HOLD: begin
        if (stop_req) begin
          st_d = S_STOP; stop_tk = 1'b1;
        end else if (tx_go && mode == MODE_TX) begin
          cnt_d = tx_cnt; idx_d = '0;
          if (tx_cnt == '0) evt[EV_TXDONE] = 1'b1; else st_d = S_TX;
        end else if (rx_go && mode != MODE_TX) begin
          cnt_d = rx_cnt; idx_d = '0;
          if (hdr_q) begin
            nl = next_lane(hdr_vld, 3'd0);
            if (nl[2]) begin lane_d = nl[1:0]; st_d = S_HDR; end
            else st_d = S_RST;
          end else if (rx_cnt == '0) evt[EV_RXDONE] = 1'b1;
          else st_d = S_RX;
        end
      end
      S_HDR: if (phy_done) begin
        evt[EV_BSENT] = 1'b1; evt[EV_NACK] = phy_nack;
        if (phy_nack && actack) st_d = S_STOP;
        else begin
          nl = next_lane(hdr_vld, {1'b0, lane_q} + 3'd1);
          if (nl[2]) lane_d = nl[1:0]; else st_d = S_RST;
        end
      end
      S_RST: if (phy_done) st_d = S_RADR;
      S_RADR: if (phy_done) begin
        evt[EV_BSENT] = 1'b1; evt[EV_NACK] = phy_nack; hdr_d = 1'b0;
        if (phy_nack && actack) st_d = S_STOP;
        else if (cnt_q == '0) begin evt[EV_RXDONE] = 1'b1; st_d = S_HOLD; end
        else st_d = S_RX;
      end
      S_TX: if (phy_done) begin
        evt[EV_BSENT] = 1'b1; evt[EV_NACK] = phy_nack;
        if (phy_nack && actack) st_d = S_STOP;
        else if (last) begin evt[EV_TXDONE] = 1'b1; st_d = S_HOLD; end
        else idx_d = idx_q + 1'b1;
      end
      S_RX: if (phy_done) begin
        evt[EV_BRCV] = 1'b1; rx_we = 1'b1;
        if (last) begin evt[EV_RXDONE] = 1'b1; st_d = S_HOLD; end
        else idx_d = idx_q + 1'b1;
      end
      S_STOP: if (phy_done) begin evt[EV_STOP] = 1'b1; st_d = S_IDLE; end
      default: st_d = S_IDLE;
    endcase
    if (!en) begin
      st_d = S_IDLE; hdr_d = 1'b0; evt = '0; rx_we = 1'b0;
      start_tk = 1'b0; stop_tk = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; idx_q <= '0; cnt_q <= '0; lane_q <= '0; hdr_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; cnt_q <= cnt_d; lane_q <= lane_d; hdr_q <= hdr_d;
    end
  end

  always_comb begin
    cmd_valid = 1'b1; cmd_op = OP_WR; cmd_byte = '0; cmd_nack = 1'b0;
    case (st_q)
      S_START, S_RST: cmd_op = OP_START;
      S_STOP:         cmd_op = OP_STOP;
      S_HDR:          cmd_byte = hdr_byte[{lane_q, 3'b000} +: 8];
      S_RADR:         cmd_byte = rd_addr;
      S_TX:           cmd_byte = tx_byte;
      S_RX: begin cmd_op = OP_RD; cmd_nack = last && lastack; end
      default:        cmd_valid = 1'b0;
    endcase
  end

  assign idx = idx_q;

  // R12: command stays put while waiting for completion
  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !phy_done) |=> (!cmd_valid || ($stable(cmd_op) && $stable(cmd_byte))))
    else $error("command changed while pending");
  // R3: byte index inside the latched chunk
  p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_TX || st_q == S_RX) |-> ({1'b0, idx_q} < cnt_q))
    else $error("byte index beyond count");
  // R4: received data never stored while transmitting
  p_rx_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> (mode != MODE_TX))
    else $error("receive store in transmit mode");
endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
  import i2cs_pkg::*;
#(
  parameter int BUF_WORDS = 8,
  localparam int BYTES = BUF_WORDS * 4,
  localparam int IDXW  = $clog2(BYTES),
  localparam int CNTW  = IDXW + 1,
  localparam int AW    = $clog2(3 * BUF_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic [7:0]    cmd_byte,
  output logic          cmd_nack,
  input  logic          phy_done,
  input  logic          phy_nack,
  input  logic [7:0]    phy_rdata
);
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_ADDR = AW'(1), A_RADDR = AW'(2),
    A_TXCNT = AW'(3), A_RXCNT = AW'(4), A_IEN = AW'(5), A_IPD = AW'(6),
    A_TXB = AW'(BUF_WORDS), A_RXB = AW'(2 * BUF_WORDS), A_END = AW'(3 * BUF_WORDS);

  logic [1:0] rs_q;
  logic rst_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= '0; else rs_q <= {rs_q[0], 1'b1};
  assign rst_s = rs_q[1];

  logic [6:0]      ctrl_q, ctrl_d;
  logic [7:0]      addr_q;
  logic            addr_v;
  logic [23:0]     raddr_q;
  logic [2:0]      raddr_v;
  logic [CNTW-1:0] txc_q, rxc_q, txc_in, rxc_in;
  logic [7:0]      txb [BYTES];
  logic [7:0]      rxb [BYTES];
  logic [IDXW-1:0] idx;
  logic            rx_we, start_tk, stop_tk, ctrl_we, tx_go, rx_go;
  logic [EV_N-1:0] evt, ien, ipd;
  int              wi;

  function automatic logic [CNTW-1:0] clampc(input logic [CNTW-1:0] c);
    return (c > CNTW'(BYTES)) ? CNTW'(BYTES) : c;
  endfunction

  assign ctrl_we = reg_wr && reg_addr == A_CTRL;
  assign tx_go   = reg_wr && reg_addr == A_TXCNT;
  assign rx_go   = reg_wr && reg_addr == A_RXCNT;
  assign txc_in  = clampc(reg_wdata[CNTW-1:0]);
  assign rxc_in  = clampc(reg_wdata[CNTW-1:0]);
  assign wi      = int'(reg_addr) - (reg_addr >= A_RXB ? 2 * BUF_WORDS : BUF_WORDS);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = reg_wdata[6:0];
    else begin
      if (start_tk) ctrl_d[3] = 1'b0;
      if (stop_tk)  ctrl_d[4] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_q <= '0; addr_q <= '0; addr_v <= 1'b0; raddr_q <= '0; raddr_v <= '0;
      txc_q <= '0; rxc_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (reg_wr && reg_addr == A_ADDR)  begin addr_q <= reg_wdata[7:0]; addr_v <= reg_wdata[24]; end
      if (reg_wr && reg_addr == A_RADDR) begin raddr_q <= reg_wdata[23:0]; raddr_v <= reg_wdata[26:24]; end
      if (tx_go) txc_q <= txc_in;
      if (rx_go) rxc_q <= rxc_in;
    end
  end

  // data buffers: storage only, no reset
  always_ff @(posedge clk) begin
    if (reg_wr && reg_addr >= A_TXB && reg_addr < A_RXB)
      for (int j = 0; j < 4; j++) txb[4 * wi + j] <= reg_wdata[8 * j +: 8];
    if (rx_we) rxb[idx] <= phy_rdata;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = {25'd0, ctrl_q};
      A_ADDR:  reg_rdata = {7'd0, addr_v, 16'd0, addr_q};
      A_RADDR: reg_rdata = {5'd0, raddr_v, raddr_q};
      A_TXCNT: reg_rdata = 32'(txc_q);
      A_RXCNT: reg_rdata = 32'(rxc_q);
      A_IEN:   reg_rdata = 32'(ien);
      A_IPD:   reg_rdata = 32'(ipd);
      default: begin
        if (reg_addr >= A_TXB && reg_addr < A_RXB)
          for (int j = 0; j < 4; j++) reg_rdata[8 * j +: 8] = txb[4 * wi + j];
        else if (reg_addr >= A_RXB && reg_addr < A_END)
          for (int j = 0; j < 4; j++) reg_rdata[8 * j +: 8] = rxb[4 * wi + j];
      end
    endcase
  end

  i2cs_seq #(.IDXW(IDXW)) u_seq (
    .clk(clk), .rst_n(rst_s), .en(ctrl_q[0]), .mode(ctrl_q[2:1]),
    .start_req(ctrl_q[3]), .stop_req(ctrl_q[4]), .lastack(ctrl_q[5]), .actack(ctrl_q[6]),
    .tx_go(tx_go), .rx_go(rx_go), .tx_cnt(txc_in), .rx_cnt(rxc_in),
    .hdr_vld({raddr_v, addr_v}), .hdr_byte({raddr_q, addr_q[7:1], 1'b0}),
    .rd_addr({addr_q[7:1], 1'b1}), .tx_byte(txb[idx]), .idx(idx), .rx_we(rx_we),
    .start_tk(start_tk), .stop_tk(stop_tk), .evt(evt),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
    .phy_done(phy_done), .phy_nack(phy_nack)
  );

  i2cs_irq #(.N(EV_N)) u_irq (
    .clk(clk), .rst_n(rst_s), .ien_we(reg_wr && reg_addr == A_IEN),
    .ipd_we(reg_wr && reg_addr == A_IPD), .wdata(reg_wdata[EV_N-1:0]),
    .evt(evt), .ien(ien), .ipd(ipd), .irq(irq)
  );

  // R2: a taken START request clears itself unless software rewrites it
  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (start_tk && !ctrl_we) |=> !ctrl_q[3])
    else $error("start request not cleared");
endmodule

// File: tb/sim_i2cs_top.sv
module sim_i2cs_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, cmd_valid, cmd_nack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;
  logic phy_done, phy_nack;
  logic [7:0] phy_rdata;

  always #2 clk = ~clk;

  i2cs_top u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack), .phy_done(phy_done),
    .phy_nack(phy_nack), .phy_rdata(phy_rdata));

  localparam int CTRL = 0, ADDR = 1, RADDR = 2, TXCNT = 3, RXCNT = 4, IEN = 5, IPD = 6,
    TXB = 8, RXB = 16;

  int nchk = 0, nfail = 0, done_flag = 0;
  int lg_op [256]; logic [7:0] lg_byte [256]; bit lg_nk [256]; int lg_n = 0;
  int ex_op [256]; logic [7:0] ex_byte [256]; bit ex_nk [256]; int ex_n = 0;
  int wrn = 0, nack_at = -1, dly = 0, hold_err = 0;
  logic [1:0] hold_op; logic [7:0] hold_b;
  logic [7:0] txd [32];

  // phase generator model
  initial begin
    phy_done = 0; phy_nack = 0; phy_rdata = 0;
    forever begin
      @(negedge clk);
      phy_done = 0; phy_nack = 0;
      if (cmd_valid === 1'b1) begin
        if (dly == 0) begin
          dly = 1 + int'($urandom % 3); hold_op = cmd_op; hold_b = cmd_byte;
        end else begin
          if (cmd_op !== hold_op || cmd_byte !== hold_b) hold_err++;
          dly--;
          if (dly == 0 && lg_n < 256) begin
            lg_op[lg_n] = int'(cmd_op); lg_byte[lg_n] = cmd_byte; lg_nk[lg_n] = cmd_nack;
            if (cmd_op == 2'd2) begin phy_nack = (wrn == nack_at); wrn++; end
            if (cmd_op == 2'd3) begin phy_rdata = 8'($urandom); lg_byte[lg_n] = phy_rdata; end
            lg_n++;
            phy_done = 1;
          end
        end
      end else dly = 0;
    end
  end

  task automatic summary();
    if (done_flag == 0) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_addr = 5'(a); reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_addr = 5'(a); #1; d = reg_rdata;
  endtask

  task automatic wait_bit(input int b, input string req);
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      rd(IPD, d);
      if (d[b]) return;
    end
    chk(0, req, 0, 32'(1) << b);
  endtask

  task automatic wait_log(input int op, input string req);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (lg_n > 0 && lg_op[lg_n-1] == op) return;
    end
    chk(0, req, 0, 32'(op));
  endtask

  task automatic push(input int op, input logic [7:0] b, input bit nk);
    ex_op[ex_n] = op; ex_byte[ex_n] = b; ex_nk[ex_n] = nk; ex_n++;
  endtask

  task automatic cmp_log(input string req);
    int bad = -1;
    for (int i = 0; i < ex_n && i < lg_n; i++)
      if (bad < 0 && (lg_op[i] != ex_op[i] || lg_nk[i] != ex_nk[i] ||
          (ex_op[i] == 2 && lg_byte[i] != ex_byte[i]))) bad = i;
    if (lg_n != ex_n) chk(0, {req, " command count"}, 32'(lg_n), 32'(ex_n));
    else if (bad >= 0)
      chk(0, $sformatf("%s command %0d op/byte/nack", req, bad),
          {lg_op[bad][7:0], 7'd0, lg_nk[bad], 8'd0, lg_byte[bad]},
          {ex_op[bad][7:0], 7'd0, ex_nk[bad], 8'd0, ex_byte[bad]});
    else chk(1, req, 0, 0);
  endtask

  task automatic rx_check(input int cnt, input int base, input string req);
    logic [31:0] d; int bad = -1; logic [7:0] a = 0, e = 0;
    for (int w = 0; w < (cnt + 3) / 4; w++) begin
      rd(RXB + w, d);
      for (int j = 0; j < 4; j++)
        if (4 * w + j < cnt && bad < 0 && d[8*j +: 8] != lg_byte[base + 4*w + j]) begin
          bad = 4 * w + j; a = d[8*j +: 8]; e = lg_byte[base + 4*w + j];
        end
    end
    chk(bad < 0, req, 32'(a), 32'(e));
  endtask

  task automatic load_tx();
    for (int i = 0; i < 32; i++) txd[i] = 8'($urandom);
    for (int w = 0; w < 8; w++) wr(TXB + w, {txd[4*w+3], txd[4*w+2], txd[4*w+1], txd[4*w]});
  endtask

  task automatic run_write(input int n, input bit act, input int nk);
    logic [31:0] d; int nn, lim; bit stopped, sawnk;
    nn = n > 32 ? 32 : n;
    load_tx();
    wr(IEN, 32'h7f); wr(IPD, 32'h7f);
    lg_n = 0; wrn = 0; nack_at = nk;
    wr(CTRL, 32'h9 | (32'(act) << 6));
    wait_bit(4, "R2");
    wr(IPD, 32'h7f); wr(TXCNT, 32'(n));
    stopped = act && nk >= 0 && nk < nn;
    sawnk = nk >= 0 && nk < nn;
    if (stopped) begin
      wait_bit(5, "R8");
      rd(IPD, d);
      chk(d[6] && !d[2], "R8 nack stop pending", d, 32'h61);
    end else begin
      wait_bit(2, "R3");
      rd(IPD, d);
      chk(d[0] && d[2] && (d[6] == sawnk), "R3 R8 pending after chunk", d, {25'd0, sawnk, 5'd5});
      wr(CTRL, 32'h11 | (32'(act) << 6));
      wait_bit(5, "R9");
    end
    ex_n = 0; lim = stopped ? nk + 1 : nn;
    push(0, 0, 0);
    for (int i = 0; i < lim; i++) push(2, txd[i], 0);
    push(1, 0, 0);
    cmp_log("R3 R8 R9");
    rd(CTRL, d);
    chk(d[4:3] == 2'b00, "R2 request bits self-clear", d, 32'(d & ~32'h18));
  endtask

  task automatic run_reg(input int n, input logic [2:0] mask, input bit la, input int m, input bit la2);
    logic [7:0] a8; logic [23:0] ra; logic [31:0] d; int rd0;
    a8 = {7'($urandom), 1'b1}; ra = 24'($urandom);
    wr(ADDR, 32'h0100_0000 | 32'(a8)); wr(RADDR, {5'd0, mask, ra});
    wr(IEN, 32'h7f); wr(IPD, 32'h7f);
    lg_n = 0; wrn = 0; nack_at = -1;
    wr(CTRL, 32'h4b | (32'(la) << 5));
    wait_bit(4, "R6");
    wr(IPD, 32'h7f); wr(RXCNT, 32'(n));
    wait_bit(3, "R4");
    ex_n = 0;
    push(0, 0, 0); push(2, {a8[7:1], 1'b0}, 0);
    for (int x = 0; x < 3; x++) if (mask[x]) push(2, ra[8*x +: 8], 0);
    push(0, 0, 0); push(2, {a8[7:1], 1'b1}, 0);
    rd0 = ex_n;
    for (int i = 0; i < n; i++) push(3, 0, la && i == n - 1);
    cmp_log("R6 R5");
    rx_check(n, rd0, "R4 first chunk packing");
    wr(CTRL, 32'h45 | (32'(la2) << 5)); wr(IPD, 32'h7f);
    lg_n = 0;
    wr(RXCNT, 32'(m));
    wait_bit(3, "R7");
    ex_n = 0;
    for (int i = 0; i < m; i++) push(3, 0, la2 && i == m - 1);
    cmp_log("R7 R5");
    rx_check(m, 0, "R4 continuation packing");
    wr(CTRL, 32'h55);
    wait_bit(5, "R9");
    chk(lg_op[lg_n-1] == 1, "R9 stop issued", 32'(lg_op[lg_n-1]), 1);
  endtask

  initial begin
    logic [31:0] d; int k;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(irq == 0 && cmd_valid == 0, "R1 outputs idle", {30'd0, irq, cmd_valid}, 0);
    rd(CTRL, d); chk(d == 0, "R1 control word", d, 0);
    rd(IPD, d);  chk(d == 0, "R1 pending word", d, 0);

    run_write(40, 1, -1);
    run_write(5, 1, 2);
    run_write(6, 0, 1);
    for (int it = 0; it < 5; it++)
      run_write(1 + int'($urandom % 32), bit'($urandom), ($urandom % 3 == 0) ? int'($urandom % 8) : -1);

    run_reg(4, 3'b101, 1, 3, 0);
    run_reg(32, 3'b000, 0, 7, 1);
    for (int it = 0; it < 3; it++)
      run_reg(1 + int'($urandom % 32), 3'($urandom), bit'($urandom), 1 + int'($urandom % 32), bit'($urandom));

    // R10 masking, write-one-to-clear and irq
    load_tx();
    wr(IEN, 32'h4); wr(IPD, 32'h7f); lg_n = 0; wrn = 0; nack_at = -1;
    wr(CTRL, 32'h49);
    wait_log(0, "R10");
    repeat (3) @(negedge clk);
    rd(IPD, d); chk(d == 0 && irq == 0, "R10 masked start", d, 0);
    wr(TXCNT, 32'd3);
    wait_bit(2, "R10");
    rd(IPD, d); chk(d == 32'h4 && irq == 1, "R10 only enabled bit", {irq, d[30:0]}, 32'h8000_0004);
    wr(IPD, 32'h4);
    rd(IPD, d); chk(d == 0 && irq == 0, "R10 write one clears", {irq, d[30:0]}, 0);
    wr(CTRL, 32'h11);
    wait_log(1, "R10");
    repeat (3) @(negedge clk);
    rd(IPD, d); chk(d == 0, "R10 masked stop", d, 0);

    // R11 abort by clearing enable, then a fresh start
    load_tx();
    wr(IEN, 32'h7f); wr(IPD, 32'h7f); lg_n = 0; wrn = 0; nack_at = -1;
    wr(CTRL, 32'h49);
    wait_bit(4, "R11");
    wr(TXCNT, 32'd32);
    for (int i = 0; i < 500 && lg_n < 5; i++) @(negedge clk);
    wr(CTRL, 32'h0);
    repeat (2) @(negedge clk);
    k = lg_n;
    chk(cmd_valid == 0, "R11 command withdrawn", 32'(cmd_valid), 0);
    repeat (30) @(negedge clk);
    chk(lg_n == k, "R11 no further commands", 32'(lg_n), 32'(k));
    wr(IPD, 32'h7f); lg_n = 0;
    wr(CTRL, 32'h49);
    wait_bit(4, "R11");
    chk(lg_n == 1 && lg_op[0] == 0, "R11 fresh start", 32'(lg_n), 1);
    wr(CTRL, 32'h0);

    chk(hold_err == 0, "R12 command held until done", 32'(hold_err), 0);
    summary();
  end
endmodule